// File: doc/BRIEF.md
# Programmable ramp delay controller

This block sits beside a frequency-ramp generator and decides, cycle by cycle, whether the ramp may step. It holds the ramp back in two situations. The first is an optional one-time wait after the ramp is activated. The second is an optional wait inserted after every burst, before the next sawtooth begins. Both waits use the same 12-bit delay word. The wait is counted in reference (phase-detector) clock cycles. A prescale select can stretch each counted unit to a programmable number of reference cycles.

A fast-lock output can be raised for the first wait after activation. The loop filter can use it to suppress the overshoot at a sawtooth transition. The generator itself is activated separately through `ramp_start_i`, which is a level. While it is low nothing runs and no delay is counted. The ramp arithmetic and the configuration registers are outside this block. All configuration inputs are expected to be stable while `ramp_start_i` is high.

Top module: `ramp_delay_ctrl`

## Requirements
- R1: While `rst_ni` is low, and after reset until activation, `ramp_run_o` and `fast_lock_o` are 0.
- R2: With `ramp_start_i` low, `ramp_run_o` and `fast_lock_o` are 0 and `ramp_end_i` has no effect. Lowering `ramp_start_i` in any state forces both outputs to 0 from the next cycle onward.
- R3: If the start-delay enable is 1, the word W is nonzero and `presc_sel_i` is 0, then `ramp_run_o` stays 0 for exactly W cycles after the cycle in which `ramp_start_i` is first sampled high, and is 1 afterwards.
- R4: If `presc_sel_i` is 1, each unit of the delay word lasts D reference cycles, where D is `presc_div_i`. A delay therefore lasts D×W cycles. A divide value of 0 acts as 1.
- R5: If the gap-delay enable is 1 and W is nonzero, a `ramp_end_i` sampled high while the ramp runs drops `ramp_run_o` from the next cycle for the full delay. `ramp_run_o` then returns to 1. This repeats for every burst.
- R6: If the gap-delay enable is 0, `ramp_end_i` has no effect and `ramp_run_o` stays 1.
- R7: If the start-delay enable is 0, `ramp_run_o` is 1 from the cycle after `ramp_start_i` is first sampled high.
- R8: A delay word of 0 skips both waits: `ramp_run_o` rises one cycle after activation and stays 1 through `ramp_end_i`.
- R9: If the fast-lock enable is 1, `fast_lock_o` is 1 exactly during the first wait after activation. That first wait is the start delay, or the first gap when the start delay is off. `fast_lock_o` is 0 at all other times, and always 0 when the enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference (phase-detector) clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| delay_word_i | input | 12 | Delay length in counted units |
| start_dly_en_i | input | 1 | Insert a wait before the first ramp |
| gap_dly_en_i | input | 1 | Insert a wait after every burst |
| fast_lock_en_i | input | 1 | Raise fast lock during the first wait |
| presc_sel_i | input | 1 | 1: each unit is presc_div_i cycles |
| presc_div_i | input | 12 | Prescale divide value |
| ramp_start_i | input | 1 | Ramp activation level |
| ramp_end_i | input | 1 | End-of-burst indication from the generator |
| ramp_run_o | output | 1 | Ramp step gate, 1 = ramp may step |
| fast_lock_o | output | 1 | Fast-lock request |

## Verification
If the delay counter loaded a wrong value, or the prescaler wrapped at the wrong count, `ramp_run_o` would rise too early or too late. Both errors show in the first wait, at the cycle where the gate is expected to rise. A stuck first-wait flag would show as `fast_lock_o` persisting into the second gap, or missing from a first gap when no start delay is used. A state machine that failed to leave a state would show one cycle after `ramp_start_i` falls, or as a gate that ignores or misreads `ramp_end_i`. The bench therefore compares both outputs on every cycle, and the first wrong cycle is reported.

// File: rtl/ramp_dly_pkg.sv
package ramp_dly_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_RUN   = 2'd2,
    ST_GAP   = 2'd3
  } dly_state_e;
endpackage

// File: rtl/ramp_dly_prescaler.sv
module ramp_dly_prescaler #(
  parameter int unsigned PW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          en_i,
  input  logic [PW-1:0] div_i,
  output logic          tick_o
);
  logic [PW-1:0] pcnt_q;
  logic [PW:0]   pcnt_inc;

  assign pcnt_inc = {1'b0, pcnt_q} + 1'b1;
  // div of 0 or 1 ticks every cycle
  assign tick_o   = en_i && (pcnt_inc >= {1'b0, div_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       pcnt_q <= '0;
    else if (clr_i)    pcnt_q <= '0;
    else if (en_i)     pcnt_q <= tick_o ? '0 : pcnt_inc[PW-1:0];
  end

  AST_PRESC_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && !clr_i) |=> (pcnt_q == '0)); // R4
endmodule

// File: rtl/ramp_dly_counter.sv
module ramp_dly_counter #(
  parameter int unsigned DW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [DW-1:0] word_i,
  input  logic          en_i,
  output logic          done_o
);
  logic [DW-1:0] cnt_q;

  assign done_o = en_i && (cnt_q == DW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (load_i)                cnt_q <= word_i;
    else if (en_i && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  AST_LOAD_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == $past(word_i))); // R3
endmodule

// File: rtl/ramp_dly_fsm.sv
module ramp_dly_fsm
  import ramp_dly_pkg::*;
#(
  parameter int unsigned DW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          end_i,
  input  logic          start_en_i,
  input  logic          gap_en_i,
  input  logic [DW-1:0] word_i,
  input  logic          done_i,
  output logic          load_o,
  output logic          in_dly_o,
  output logic          run_o,
  output logic          first_o
);
  dly_state_e state_q, state_d;
  logic       first_q;
  logic       word_nz;

  assign word_nz = (word_i != '0);

  always_comb begin
    state_d = state_q;
    if (!start_i) state_d = ST_IDLE;
    else begin
      unique case (state_q)
        ST_IDLE:  state_d = (start_en_i && word_nz) ? ST_START : ST_RUN;
        ST_START: if (done_i) state_d = ST_RUN;
        ST_RUN:   if (end_i && gap_en_i && word_nz) state_d = ST_GAP;
        ST_GAP:   if (done_i) state_d = ST_RUN;
        default:  state_d = ST_IDLE;
      endcase
    end
  end

  assign load_o   = ((state_d == ST_START) && (state_q != ST_START)) ||
                    ((state_d == ST_GAP)   && (state_q != ST_GAP));
  assign in_dly_o = (state_q == ST_START) || (state_q == ST_GAP);
  assign run_o    = (state_q == ST_RUN);
  assign first_o  = first_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      first_q <= 1'b1;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE)          first_q <= 1'b1;
      else if (in_dly_o && done_i)     first_q <= 1'b0;
    end
  end

  AST_ZERO_SKIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && start_i && !word_nz) |=> (state_q == ST_RUN)); // R8
  AST_NO_START_DLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && start_i && !start_en_i) |=> (state_q == ST_RUN)); // R7
  AST_GAP_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && start_i && !gap_en_i) |=> (state_q == ST_RUN)); // R6
  AST_DLY_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_dly_o && done_i && start_i) |=> (state_q == ST_RUN)); // R5
endmodule

// File: rtl/ramp_delay_ctrl.sv
module ramp_delay_ctrl #(
  parameter int unsigned DW = 12,
  parameter int unsigned PW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] delay_word_i,
  input  logic          start_dly_en_i,
  input  logic          gap_dly_en_i,
  input  logic          fast_lock_en_i,
  input  logic          presc_sel_i,
  input  logic [PW-1:0] presc_div_i,
  input  logic          ramp_start_i,
  input  logic          ramp_end_i,
  output logic          ramp_run_o,
  output logic          fast_lock_o
);
  logic load, in_dly, first, done, presc_tick, unit_tick;

  ramp_dly_fsm #(.DW(DW)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (ramp_start_i),
    .end_i      (ramp_end_i),
    .start_en_i (start_dly_en_i),
    .gap_en_i   (gap_dly_en_i),
    .word_i     (delay_word_i),
    .done_i     (done),
    .load_o     (load),
    .in_dly_o   (in_dly),
    .run_o      (ramp_run_o),
    .first_o    (first)
  );

  ramp_dly_prescaler #(.PW(PW)) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (load),
    .en_i   (in_dly),
    .div_i  (presc_div_i),
    .tick_o (presc_tick)
  );

  assign unit_tick = in_dly && (presc_sel_i ? presc_tick : 1'b1);

  ramp_dly_counter #(.DW(DW)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .word_i (delay_word_i),
    .en_i   (unit_tick),
    .done_o (done)
  );

  assign fast_lock_o = fast_lock_en_i && first && in_dly;

  AST_FL_NOT_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fast_lock_o |-> !ramp_run_o); // R9
  AST_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ramp_start_i |=> (!ramp_run_o && !fast_lock_o)); // R2
endmodule

// File: tb/ramp_delay_ctrl_bench.sv
module ramp_delay_ctrl_bench;
  typedef struct {
    logic run;
    logic fl;
    string req;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] word = '0;
  logic        sd_en = 1'b0, gap_en = 1'b0, fl_en = 1'b0, sel = 1'b0;
  logic [11:0] div = '0;
  logic        start = 1'b0, rend = 1'b0;
  logic        run, fl;

  int n_chk = 0;
  int n_err = 0;
  exp_t q[$];

  always #4 clk = ~clk;

  ramp_delay_ctrl u_ramp_delay_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .delay_word_i(word),
    .start_dly_en_i(sd_en), .gap_dly_en_i(gap_en), .fast_lock_en_i(fl_en),
    .presc_sel_i(sel), .presc_div_i(div),
    .ramp_start_i(start), .ramp_end_i(rend),
    .ramp_run_o(run), .fast_lock_o(fl)
  );

  task automatic chk(input logic r, input logic f, input string req);
    n_chk++;
    if (run !== r || fl !== f) begin
      n_err++;
      $display("FAIL %s: run=%b fl=%b expected run=%b fl=%b at %0t",
               req, run, fl, r, f, $time);
    end
  endtask

  // drive one cycle; expectation is for outputs after the next edge
  task automatic step(input logic s, input logic e, input logic r,
                      input logic f, input string req);
    exp_t it;
    @(negedge clk);
    start = s;
    rend  = e;
    it.run = r; it.fl = f; it.req = req;
    q.push_back(it);
  endtask

  task automatic steps(input int n, input logic s, input logic r,
                       input logic f, input string req);
    for (int i = 0; i < n; i++) step(s, 1'b0, r, f, req);
  endtask

  always begin
    @(posedge clk);
    #2;
    if (q.size() > 0) begin
      exp_t it;
      it = q.pop_front();
      chk(it.run, it.fl, it.req);
    end
  end

  task automatic cfg(input int w, input logic s, input logic g, input logic f,
                     input logic ps, input int d);
    @(negedge clk);
    word = 12'(w); sd_en = s; gap_en = g; fl_en = f; sel = ps; div = 12'(d);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #(8 * 20000);
    n_err++;
    n_chk++;
    $display("FAIL watchdog: run=%b fl=%b expected completion", run, fl);
    finish_run();
  end

  initial begin
    #10;
    chk(1'b0, 1'b0, "R1 in reset");
    @(negedge clk);
    rst_n = 1'b1;
    steps(3, 1'b0, 1'b0, 1'b0, "R1 after reset");

    // R2: ramp_end ignored while inactive
    cfg(3, 1'b0, 1'b1, 1'b1, 1'b0, 0);
    step(1'b0, 1'b1, 1'b0, 1'b0, "R2 end while idle");
    steps(2, 1'b0, 1'b0, 1'b0, "R2 idle");

    // R3/R9/R5: start delay 5, gaps of 5, fast lock on first only
    cfg(5, 1'b1, 1'b1, 1'b1, 1'b0, 0);
    steps(5, 1'b1, 1'b0, 1'b1, "R3 R9 start delay");
    steps(3, 1'b1, 1'b1, 1'b0, "R3 run after delay");
    for (int b = 0; b < 2; b++) begin
      step(1'b1, 1'b1, 1'b0, 1'b0, "R5 R9 gap entry");
      steps(4, 1'b1, 1'b0, 1'b0, "R5 gap hold");
      steps(2, 1'b1, 1'b1, 1'b0, "R5 gap exit");
    end
    steps(2, 1'b0, 1'b0, 1'b0, "R2 stop");

    // R7/R9: no start delay, first gap carries fast lock
    cfg(2, 1'b0, 1'b1, 1'b1, 1'b0, 0);
    steps(2, 1'b1, 1'b1, 1'b0, "R7 immediate run");
    step(1'b1, 1'b1, 1'b0, 1'b1, "R9 first gap");
    step(1'b1, 1'b0, 1'b0, 1'b1, "R9 first gap");
    step(1'b1, 1'b0, 1'b1, 1'b0, "R5 gap done");
    step(1'b1, 1'b1, 1'b0, 1'b0, "R9 second gap no fl");
    step(1'b1, 1'b0, 1'b0, 1'b0, "R9 second gap no fl");
    step(1'b1, 1'b0, 1'b1, 1'b0, "R5 gap done");
    step(1'b0, 1'b0, 1'b0, 1'b0, "R2 stop");

    // R4: prescaled 3 x 4, fast lock disabled
    cfg(4, 1'b1, 1'b0, 1'b0, 1'b1, 3);
    steps(12, 1'b1, 1'b0, 1'b0, "R4 prescaled delay");
    steps(2, 1'b1, 1'b1, 1'b0, "R4 run after 12");
    step(1'b0, 1'b0, 1'b0, 1'b0, "R2 stop");
    cfg(3, 1'b1, 1'b0, 1'b0, 1'b1, 0);
    steps(3, 1'b1, 1'b0, 1'b0, "R4 div zero");
    step(1'b1, 1'b0, 1'b1, 1'b0, "R4 div zero run");
    step(1'b0, 1'b0, 1'b0, 1'b0, "R2 stop");

    // R8: zero word skips both waits
    cfg(0, 1'b1, 1'b1, 1'b1, 1'b0, 0);
    step(1'b1, 1'b0, 1'b1, 1'b0, "R8 skip start");
    step(1'b1, 1'b1, 1'b1, 1'b0, "R8 skip gap");
    steps(2, 1'b1, 1'b1, 1'b0, "R8 run");
    step(1'b0, 1'b0, 1'b0, 1'b0, "R2 stop");

    // R6: gap disabled
    cfg(3, 1'b0, 1'b0, 1'b1, 1'b0, 0);
    step(1'b1, 1'b0, 1'b1, 1'b0, "R7 run");
    step(1'b1, 1'b1, 1'b1, 1'b0, "R6 end ignored");
    steps(3, 1'b1, 1'b1, 1'b0, "R6 still running");
    step(1'b0, 1'b0, 1'b0, 1'b0, "R2 stop");

    // R2: abort during start delay, restart gets fresh delay
    cfg(5, 1'b1, 1'b0, 1'b1, 1'b0, 0);
    steps(2, 1'b1, 1'b0, 1'b1, "R9 start delay");
    steps(2, 1'b0, 1'b0, 1'b0, "R2 abort in delay");
    steps(5, 1'b1, 1'b0, 1'b1, "R3 restart full delay");
    step(1'b1, 1'b0, 1'b1, 1'b0, "R3 run");
    step(1'b0, 1'b0, 1'b0, 1'b0, "R2 stop");

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule